// File: doc/BRIEF.md
# I2C-Style Serial Byte Engine

This block moves single 8-bit frames over a two-wire open-drain bus. Each frame is eight data bits, most significant first, followed by a ninth acknowledge bit. In master mode the block makes its own serial clock from a programmable divider. In slave mode it follows the clock that another device drives on the bus. Both outputs pull their line low only. A released line reads back high.

Reception uses the transmit path. To receive, software loads a byte (0xFF leaves the data line free) with transmit enabled, and sets receive enable to keep the sampled bits. Each change of the driven data line waits until the clock line has been seen low. An optional delay can then hold the change back further. The block pulses an event output on start and stop conditions and on acknowledge or missing acknowledge. It keeps flags for overrun and for lost arbitration. A selection input chooses when the arbitration flag is updated.

Top module: `i2c_byte_engine`

## Requirements
- R1: A frame starts only while `tx_en` is 1, the transmit buffer is loaded (`tx_empty` = 0) and the synchronized clock line is high. `tx_wr` loads `tx_data` and clears `tx_empty`. Taking the byte for a frame sets `tx_empty` to 1.
- R2: In master mode a frame is exactly 9 clock pulses on `scl_oe`. Each pulse has a period of 2·(`brg_div`+1) cycles of `clk`, and `scl_oe` is 0 outside a frame.
- R3: In slave mode the block shifts on edges of `scl_in`, never drives `scl_oe`, and does not start a frame while `scl_in` is low.
- R4: Data goes out most significant bit first, with `sda_oe` = 1 for a 0 bit. `sda_oe` changes only while the synchronized clock is low. The change appears 3 + D rising edges of `clk` after `scl_in` falls, where D = 0 for `sda_dly_sel` = 0 and D = `sda_dly_sel`+1 (2 to 8) otherwise.
- R5: With `rx_en` = 1, the 8 bus bits sampled on clock rises go to `rx_data` at the 8th rise, and `rx_full` becomes 1. With `rx_en` = 0 nothing is stored. `rx_rd` clears `rx_full`.
- R6: In the ninth bit the block pulls the data line low if `rx_en` = 1 and releases it otherwise. At the ninth rise it pulses `ev_ack` if the line is low, or `ev_nack` if it is high.
- R7: A falling data line while the clock is high pulses `ev_start`. A rising data line while the clock is high pulses `ev_stop`. Data changes while the clock is low raise neither.
- R8: If the 8th bit arrives while `rx_full` = 1, `overrun` becomes 1 and `rx_data` and `rx_full` stay unchanged. `rx_rd` clears `overrun`.
- R9: If a released data bit reads back low, the block stops driving for the rest of the data bits. `arb_lost` becomes 1 at that rise when `arb_at_end` = 0, or at the ninth rise when `arb_at_end` = 1. The flag clears when the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the divider's count source |
| rst_n | input | 1 | Active-low asynchronous reset |
| master | input | 1 | 1 = internal clock generation, 0 = follow external clock |
| brg_div | input | 8 | Divider setting n, SCL period 2·(n+1) clocks |
| sda_dly_sel | input | 3 | Data output delay select, 0 = none |
| arb_at_end | input | 1 | 1 = report lost arbitration at frame end |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable, also enables acknowledge drive |
| tx_wr | input | 1 | Load strobe for the transmit buffer |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read strobe, clears receive full and overrun |
| scl_in | input | 1 | Clock line as seen on the bus |
| sda_in | input | 1 | Data line as seen on the bus |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| tx_empty | output | 1 | Transmit buffer empty |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_data | output | 8 | Received byte |
| overrun | output | 1 | Byte lost because the buffer was unread |
| arb_lost | output | 1 | Arbitration lost in the current or last frame |
| ev_start | output | 1 | One-cycle pulse on start condition |
| ev_stop | output | 1 | One-cycle pulse on stop condition |
| ev_ack | output | 1 | One-cycle pulse, acknowledge seen |
| ev_nack | output | 1 | One-cycle pulse, acknowledge missing |

## Verification
The bench measures the data output latency from its own clock-line fall for no delay and for the longest delay. An off-by-one delay counter, or an output that updates while the clock is high, shows up there as a wrong cycle count. It pulls bits low against transmitted ones in both arbitration timings. A design that keeps driving after the loss, or updates the flag at the wrong rise, then corrupts later bits or shows the flag too early or too late. It also loads a second byte over an unread one, expecting the first byte to survive, and holds the external clock low while data waits, where a premature start would empty the buffer.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
    parameter int unsigned BYTE_W = 8;
    parameter int unsigned DIV_W  = 8;
    parameter int unsigned DLY_W  = 3;
    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
    localparam int unsigned DC_W  = DLY_W + 1;

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] tsh;
        logic [BYTE_W-1:0] rsh;
        logic [BYTE_W-1:0] tbuf;
        logic              tempty;
        logic [BYTE_W-1:0] rbuf;
        logic              rfull;
        logic              ovr;
        logic              arb;
        logic              arb_pend;
        logic              lost;
        logic              sda_drv;
        logic              pend;
        logic              pend_val;
        logic [DC_W-1:0]   dcnt;
        logic              scl_p;
        logic              sda_p;
        logic              ev_start;
        logic              ev_stop;
        logic              ev_ack;
        logic              ev_nack;
    } eng_t;
endpackage

// File: rtl/i2cx_sync.sv
module i2cx_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/i2cx_sclgen.sv
module i2cx_sclgen #(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned PULSES = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DIV_W-1:0] div,
    output logic             scl_low
);
    localparam int unsigned HALVES = 2 * PULSES;
    localparam int unsigned HC_W   = $clog2(HALVES + 1);

    logic             run_d, run_q, low_d, low_q;
    logic [HC_W-1:0]  hc_d, hc_q;
    logic [DIV_W-1:0] dc_d, dc_q;

    always_comb begin
        run_d = run_q;
        low_d = low_q;
        hc_d  = hc_q;
        dc_d  = dc_q;
        if (go) begin
            run_d = 1'b1;
            low_d = 1'b0;
            hc_d  = '0;
            dc_d  = '0;
        end else if (run_q) begin
            if (dc_q == div) begin
                dc_d  = '0;
                low_d = ~low_q;
                hc_d  = hc_q + 1'b1;
                if (hc_q == HC_W'(HALVES - 1)) run_d = 1'b0;
            end else begin
                dc_d = dc_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            low_q <= 1'b0;
            hc_q  <= '0;
            dc_q  <= '0;
        end else begin
            run_q <= run_d;
            low_q <= low_d;
            hc_q  <= hc_d;
            dc_q  <= dc_d;
        end
    end

    assign scl_low = low_q;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2cx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  logic [DIV_W-1:0]  brg_div,
    input  logic [DLY_W-1:0]  sda_dly_sel,
    input  logic              arb_at_end,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              rx_rd,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              tx_empty,
    output logic              rx_full,
    output logic [BYTE_W-1:0] rx_data,
    output logic              overrun,
    output logic              arb_lost,
    output logic              ev_start,
    output logic              ev_stop,
    output logic              ev_ack,
    output logic              ev_nack
);
    eng_t            d, q;
    logic [1:0]      lines_s;
    logic            scl_s, sda_s, fall, rise, start_ok, go, nv;
    logic [DC_W-1:0] dly_cyc;

    i2cx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    i2cx_sclgen #(.DIV_W(DIV_W), .PULSES(BYTE_W + 1)) u_sclgen (
        .clk(clk), .rst_n(rst_n), .go(go), .div(brg_div), .scl_low(scl_oe)
    );

    assign fall     = q.scl_p & ~scl_s;
    assign rise     = ~q.scl_p & scl_s;
    assign start_ok = ~q.busy & tx_en & ~q.tempty & scl_s;
    assign go       = start_ok & master;
    assign dly_cyc  = (sda_dly_sel == '0) ? '0 : DC_W'(sda_dly_sel) + DC_W'(1);

    always_comb begin
        d          = q;
        nv         = 1'b0;
        d.scl_p    = scl_s;
        d.sda_p    = sda_s;
        d.ev_start = q.scl_p & scl_s & q.sda_p & ~sda_s;
        d.ev_stop  = q.scl_p & scl_s & ~q.sda_p & sda_s;
        d.ev_ack   = 1'b0;
        d.ev_nack  = 1'b0;

        if (start_ok) begin
            d.busy     = 1'b1;
            d.cnt      = '0;
            d.tsh      = q.tbuf;
            d.tempty   = 1'b1;
            d.lost     = 1'b0;
            d.arb      = 1'b0;
            d.arb_pend = 1'b0;
        end
        if (tx_wr) begin
            d.tbuf   = tx_data;
            d.tempty = 1'b0;
        end
        if (rx_rd) begin
            d.rfull = 1'b0;
            d.ovr   = 1'b0;
        end

        // delayed data-line update, held while the clock is high
        if (q.pend && !scl_s) begin
            if (q.dcnt <= DC_W'(1)) begin
                d.sda_drv = q.pend_val;
                d.pend    = 1'b0;
            end else begin
                d.dcnt = q.dcnt - 1'b1;
            end
        end

        if (fall) begin
            if (q.busy) begin
                if (q.cnt < CNT_W'(BYTE_W)) begin
                    nv    = ~q.tsh[BYTE_W-1] & ~q.lost;
                    d.tsh = {q.tsh[BYTE_W-2:0], 1'b0};
                end else begin
                    nv = rx_en;
                end
            end
            if (dly_cyc == '0) begin
                d.sda_drv = nv;
                d.pend    = 1'b0;
            end else begin
                d.pend     = 1'b1;
                d.pend_val = nv;
                d.dcnt     = dly_cyc;
            end
        end

        if (rise && q.busy) begin
            if (q.cnt < CNT_W'(BYTE_W)) begin
                d.rsh = {q.rsh[BYTE_W-2:0], sda_s};
                if (!q.sda_drv && !q.lost && !sda_s) begin
                    d.lost = 1'b1;
                    if (arb_at_end) d.arb_pend = 1'b1;
                    else            d.arb      = 1'b1;
                end
                if (q.cnt == CNT_W'(BYTE_W - 1) && rx_en) begin
                    if (q.rfull) begin
                        d.ovr = 1'b1;
                    end else begin
                        d.rbuf  = {q.rsh[BYTE_W-2:0], sda_s};
                        d.rfull = 1'b1;
                    end
                end
                d.cnt = q.cnt + 1'b1;
            end else begin
                d.ev_ack  = ~sda_s;
                d.ev_nack = sda_s;
                d.busy    = 1'b0;
                if (q.arb_pend) d.arb = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.tempty <= 1'b1;
            q.scl_p  <= 1'b1;
            q.sda_p  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe   = q.sda_drv;
    assign tx_empty = q.tempty;
    assign rx_full  = q.rfull;
    assign rx_data  = q.rbuf;
    assign overrun  = q.ovr;
    assign arb_lost = q.arb;
    assign ev_start = q.ev_start;
    assign ev_stop  = q.ev_stop;
    assign ev_ack   = q.ev_ack;
    assign ev_nack  = q.ev_nack;

    AST_START_COND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(tx_en && !q.tempty && scl_s))
        else $error("frame started without its conditions"); // R1
    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sda_drv) |-> $past(!scl_s))
        else $error("data drive changed with clock high"); // R4
    AST_RX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rfull) |-> $past(rx_en))
        else $error("byte stored without receive enable"); // R5
    AST_ACK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ev_ack || q.ev_nack) |-> (!q.busy && $past(q.busy)))
        else $error("acknowledge event outside frame end"); // R6
    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> ($stable(q.rbuf) && q.rfull))
        else $error("overrun changed the stored byte"); // R8
endmodule

// File: tb/test_i2c_byte_engine.sv
module test_i2c_byte_engine;
    localparam int H = 24;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       master = 1'b1, arb_at_end = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
    logic       tx_wr = 1'b0, rx_rd = 1'b0;
    logic [7:0] brg_div = 8'd5, tx_data = 8'h00;
    logic [2:0] sda_dly_sel = 3'd0;
    logic       tb_scl_low = 1'b0, tb_sda_low = 1'b0;
    logic       scl_in, sda_in, scl_oe, sda_oe, tx_empty, rx_full, overrun, arb_lost;
    logic       ev_start, ev_stop, ev_ack, ev_nack;
    logic [7:0] rx_data;

    int n_cmp = 0, n_bad = 0, n_start = 0, n_stop = 0, n_ack = 0, n_nack = 0;
    int n_sclp = 0, n_slave_scl = 0, dly_meas = 0;
    bit done = 0;
    logic scl_prev = 1'b0;
    logic [8:0] sda_snap, arb_snap;

    assign scl_in = ~(scl_oe | tb_scl_low);
    assign sda_in = ~(sda_oe | tb_sda_low);

    i2c_byte_engine i_i2c_byte_engine (
        .clk(clk), .rst_n(rst_n), .master(master), .brg_div(brg_div),
        .sda_dly_sel(sda_dly_sel), .arb_at_end(arb_at_end), .tx_en(tx_en),
        .rx_en(rx_en), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .tx_empty(tx_empty), .rx_full(rx_full), .rx_data(rx_data),
        .overrun(overrun), .arb_lost(arb_lost), .ev_start(ev_start),
        .ev_stop(ev_stop), .ev_ack(ev_ack), .ev_nack(ev_nack)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (ev_start) n_start++;
        if (ev_stop)  n_stop++;
        if (ev_ack)   n_ack++;
        if (ev_nack)  n_nack++;
        if (scl_oe && !scl_prev) n_sclp++;
        if (!master && scl_oe) n_slave_scl++;
        scl_prev = scl_oe;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int dly_exp(input int sel);
        return 3 + ((sel == 0) ? 0 : sel + 1);
    endfunction

    // returns {lost, bus byte} for a frame of b against bench pulls
    function automatic logic [8:0] bus_run(input logic [7:0] b, input logic [7:0] pull);
        logic       lost = 1'b0;
        logic [7:0] rx;
        for (int i = 7; i >= 0; i--) begin
            logic t;
            t = lost ? 1'b1 : b[i];
            rx[i] = t & ~pull[i];
            if (!lost && t && !rx[i]) lost = 1'b1;
        end
        return {lost, rx};
    endfunction

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk); tx_data = b; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic rd_byte();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_end();
        int base = n_ack + n_nack;
        for (int k = 0; k < 6000 && (n_ack + n_nack) == base; k++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic slave_pulses(input logic [8:0] pull);
        dly_meas = 0;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk); tb_scl_low = 1'b1;
            for (int k = 1; k <= H/2; k++) begin
                @(negedge clk);
                if (i == 0 && dly_meas == 0 && sda_oe) dly_meas = k;
            end
            tb_sda_low = pull[8-i];
            repeat (H/2) @(negedge clk);
            tb_scl_low = 1'b0;
            repeat (H) @(negedge clk);
            sda_snap[i] = sda_oe;
            arb_snap[i] = arb_lost;
        end
        tb_sda_low = 1'b0;
    endtask

    initial begin
        int p0, per, a0, nk0;
        logic [8:0] r;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        chk("R1 reset tx_empty", tx_empty, 1);
        chk("R5 reset rx_full", rx_full, 0);
        chk("R4 reset sda_oe", sda_oe, 0);
        chk("R2 reset scl_oe", scl_oe, 0);
        chk("R8 reset overrun", overrun, 0);
        chk("R9 reset arb_lost", arb_lost, 0);

        // R7 start and stop detection
        tb_sda_low = 1'b1; repeat (6) @(negedge clk);
        chk("R7 start", n_start, 1);
        tb_sda_low = 1'b0; repeat (6) @(negedge clk);
        chk("R7 stop", n_stop, 1);
        tb_scl_low = 1'b1; repeat (6) @(negedge clk);
        tb_sda_low = 1'b1; repeat (6) @(negedge clk);
        tb_sda_low = 1'b0; repeat (6) @(negedge clk);
        tb_scl_low = 1'b0; repeat (6) @(negedge clk);
        chk("R7 no event with clock low", n_start + n_stop, 2);

        // R2 master clock, R5/R6 loopback receive with acknowledge
        master = 1'b1; brg_div = 8'd5; tx_en = 1'b1; rx_en = 1'b1;
        p0 = n_sclp; a0 = n_ack;
        wr_byte(8'hA5);
        for (int k = 0; k < 200 && !scl_oe; k++) @(negedge clk);
        per = 0;
        for (int k = 0; k < 200 && scl_oe; k++) begin @(negedge clk); per++; end
        for (int k = 0; k < 200 && !scl_oe; k++) begin @(negedge clk); per++; end
        chk("R2 clock period", per, 12);
        wait_end();
        chk("R2 pulse count", n_sclp - p0, 9);
        chk("R2 released after frame", scl_oe, 0);
        chk("R5 loopback data", rx_data, 8'hA5);
        chk("R5 rx_full", rx_full, 1);
        chk("R6 ack seen", n_ack - a0, 1);
        rd_byte();
        chk("R5 read clears", rx_full, 0);

        // R1 no start without transmit enable
        tx_en = 1'b0; p0 = n_sclp;
        wr_byte(8'h3C);
        chk("R1 write clears empty", tx_empty, 0);
        repeat (60) @(negedge clk);
        chk("R1 held while disabled", tx_empty, 0);
        chk("R1 no clock while disabled", n_sclp - p0, 0);

        // R5/R6 receive disabled: no store, missing acknowledge
        rx_en = 1'b0; nk0 = n_nack; tx_en = 1'b1;
        wait_end();
        chk("R1 taken once enabled", tx_empty, 1);
        chk("R5 no store when disabled", rx_full, 0);
        chk("R6 nack seen", n_nack - nk0, 1);

        // R8 overrun
        rx_en = 1'b1;
        wr_byte(8'h81); wait_end();
        wr_byte(8'h7E); wait_end();
        chk("R8 overrun set", overrun, 1);
        chk("R8 data kept", rx_data, 8'h81);
        chk("R8 full kept", rx_full, 1);
        rd_byte();
        chk("R8 read clears overrun", overrun, 0);

        // R3 slave: no start while clock low; R4 output delays
        master = 1'b0; rx_en = 1'b0; sda_dly_sel = 3'd3;
        tb_scl_low = 1'b1; repeat (20) @(negedge clk);
        wr_byte(8'h4B); repeat (20) @(negedge clk);
        chk("R3 no start with clock low", tx_empty, 0);
        tb_scl_low = 1'b0; repeat (6) @(negedge clk);
        chk("R3 start with clock high", tx_empty, 1);
        nk0 = n_nack;
        slave_pulses(9'h000);
        chk("R4 delay sel 3", dly_meas, dly_exp(3));
        chk("R4 bit order", {sda_snap[0], sda_snap[1], sda_snap[7]}, 3'b100);
        chk("R6 slave nack", n_nack - nk0, 1);
        foreach (i_sel_list[j]) begin
            sda_dly_sel = i_sel_list[j];
            wr_byte(8'h5A); repeat (6) @(negedge clk);
            slave_pulses(9'h000);
            chk("R4 delay", dly_meas, dly_exp(i_sel_list[j]));
        end
        chk("R3 slave never drives clock", n_slave_scl, 0);

        // R9 arbitration, both timings: byte 1011_0110, pull bit index 2
        for (int m = 0; m < 2; m++) begin
            arb_at_end = m[0]; sda_dly_sel = 3'd1;
            wr_byte(8'hB6); repeat (6) @(negedge clk);
            slave_pulses(9'b001_0000_00);
            chk("R9 flag at lost bit", arb_snap[2], (m == 0) ? 1 : 0);
            chk("R9 flag at frame end", arb_snap[8], 1);
            chk("R9 released after loss", sda_snap[4], 0);
        end

        // mixed random frames
        for (int it = 0; it < 24; it++) begin
            logic [7:0] b, pull;
            int sel, dd;
            b = 8'($urandom); sel = $urandom % 8; rx_en = 1'($urandom);
            dd = (sel == 0) ? 0 : sel + 1;
            sda_dly_sel = 3'(sel);
            a0 = n_ack; nk0 = n_nack;
            if (rx_full) rd_byte();
            if (it[0]) begin
                master = 1'b1; brg_div = 8'(dd + 4 + $urandom % 4);
                wr_byte(b); wait_end();
                r = {1'b0, b};
            end else begin
                master = 1'b0; arb_at_end = 1'($urandom);
                pull = ($urandom % 3 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
                wr_byte(b); repeat (6) @(negedge clk);
                slave_pulses({pull, 1'b0});
                r = bus_run(b, pull);
                chk("R9 random arbitration", arb_lost, r[8]);
            end
            if (rx_en) chk("R5 random data", rx_data, r[7:0]);
            else       chk("R5 random no store", rx_full, 0);
            chk("R6 random ack", n_ack - a0, rx_en ? 1 : 0);
            chk("R6 random nack", n_nack - nk0, rx_en ? 0 : 1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    int i_sel_list[2] = '{0, 7};

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule